// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit forms the memory address of one operand access for a processor with 16-bit registers and a 20-bit physical address space. For data accesses it first builds a 16-bit effective offset from the selected addressing mode: a constant alone, a base register alone, a base plus constants, or a base plus an index scaled by 1, 2, 4 or 8 plus constants. It then adds that offset to a segment value moved up by four bit positions. Two displacement fields, a leading one and an inner one, are both summed into the offset.

Instruction fetches and stack accesses do not use the addressing mode. A fetch pairs the code segment with the instruction pointer, and a stack access pairs the stack segment with the stack pointer. A data access uses the data segment unless an override selects another segment register. An immediate-mode request makes no memory access. It returns its constant on a separate operand output instead. All results are registered and appear one clock after the request strobe.

Top module: `seg_agu`

## Requirements
- R1: The physical address equals the 16-bit segment value times 16 plus the 16-bit offset, taken modulo 2^20.
- R2: Different segment:offset pairs that name the same location give the same physical address. For example, segment 0x0000 with offset 0x0040 and segment 0x0004 with offset 0x0000 both give 0x00040.
- R3: Mode 3'b001 (direct) uses an offset equal to leading displacement plus inner displacement. A leading 20 with an inner 40 gives an offset of 60.
- R4: Mode 3'b010 (register indirect) uses an offset equal to the base value. Both displacements and the index have no effect.
- R5: Mode 3'b011 (base plus displacement) uses an offset equal to base + leading + inner. The index has no effect.
- R6: Mode 3'b100 (scaled index) uses an offset equal to base + (index shifted left by the scale code) + leading + inner. The scale codes 2'b00, 2'b01, 2'b10 and 2'b11 multiply by 1, 2, 4 and 8.
- R7: All offset arithmetic wraps modulo 2^16.
- R8: Access kind 2'b10 (fetch) uses segment slot 1 (code) with the instruction-pointer input. Kind 2'b01 (stack) uses slot 2 (stack) with the stack-pointer input. For both kinds, the mode, the displacements and the override inputs have no effect.
- R9: Kind 2'b00 (data) uses segment slot 3 (data) when the override enable is low. When it is high, it uses the slot named by the override select. Slot k occupies bits [16k+15:16k] of the segment bus, and slot 0 is the extra segment.
- R10: The memory valid output is high in exactly the cycle after a request is sampled that forms an address. The physical address output changes only in that cycle and otherwise holds its value.
- R11: Mode 3'b000 (immediate) on a data request raises the operand valid output one cycle later and presents the leading displacement on the operand output. The memory valid output stays low and the physical address holds. The two valid outputs are never high together.
- R12: While reset is asserted and after it is released, both valid outputs are low, and the address and operand outputs are zero until the first request.
- R13: A data request with a reserved mode (3'b101 to 3'b111), or any request of kind 2'b11, raises neither valid output and leaves the address and operand outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one access per high cycle |
| kind_i | input | 2 | Access kind: 00 data, 01 stack, 10 fetch, 11 reserved |
| mode_i | input | 3 | Addressing mode for data accesses |
| base_i | input | 16 | Base register value |
| index_i | input | 16 | Index register value |
| scale_i | input | 2 | Index shift amount (×1, ×2, ×4, ×8) |
| disp_lead_i | input | 16 | Leading displacement; also the immediate constant |
| disp_inner_i | input | 16 | Inner displacement |
| ip_i | input | 16 | Instruction pointer |
| sp_i | input | 16 | Stack pointer |
| ovr_en_i | input | 1 | Segment override enable for data accesses |
| ovr_sel_i | input | 2 | Override segment slot |
| seg_regs_i | input | 64 | Four 16-bit segment values, slot k at bits [16k+15:16k] |
| paddr_o | output | 20 | Registered physical address |
| mem_valid_o | output | 1 | Physical address valid strobe |
| imm_o | output | 16 | Registered immediate operand |
| imm_valid_o | output | 1 | Immediate operand valid strobe |

## Verification
The bench sweeps every mode code, every scale code and every segment choice (the default and each of the four override slots) against three operand sets. The first set holds small values whose sums cannot carry. It separates the modes by which fields they add and checks the 20 + 40 displacement case. The second set puts large base, index and displacement values together so that both the 16-bit offset and the 20-bit physical sum wrap. The third sets index to 0xFFFF with zero displacements, which shows that each scale code moves the index by the right amount and drops the bits shifted out. Fetch and stack accesses are tried with hostile mode, displacement and override values to show that these inputs are ignored, and the aliasing pair shows that two segment:offset pairs meet at one address.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

  typedef enum logic [2:0] {
    AM_IMM      = 3'd0,
    AM_DIRECT   = 3'd1,
    AM_REGIND   = 3'd2,
    AM_BASEDISP = 3'd3,
    AM_BASEIDX  = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    AK_DATA  = 2'd0,
    AK_STACK = 2'd1,
    AK_FETCH = 2'd2,
    AK_RSVD  = 2'd3
  } akind_e;

  // segment slot positions on the packed segment bus
  localparam int SLOT_EXTRA = 0;
  localparam int SLOT_CODE  = 1;
  localparam int SLOT_STACK = 2;
  localparam int SLOT_DATA  = 3;

endpackage

// File: rtl/seg_agu_offset.sv
// Effective offset former for data accesses: base, scaled index, summed displacements.
module seg_agu_offset
  import seg_agu_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int SCL_W = 2
) (
  input  logic [2:0]       mode_i,
  input  logic [OFS_W-1:0] base_i,
  input  logic [OFS_W-1:0] index_i,
  input  logic [SCL_W-1:0] scale_i,
  input  logic [OFS_W-1:0] disp_lead_i,
  input  logic [OFS_W-1:0] disp_inner_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             is_mem_o,
  output logic             is_imm_o
);

  logic [OFS_W-1:0] scaled_idx;
  logic [OFS_W-1:0] disp_sum;

  always_comb begin
    scaled_idx = index_i << scale_i;
    disp_sum   = disp_lead_i + disp_inner_i;
  end

  always_comb begin
    ofs_o    = '0;
    is_mem_o = 1'b0;
    is_imm_o = 1'b0;
    case (amode_e'(mode_i))
      AM_IMM: begin
        is_imm_o = 1'b1;
      end
      AM_DIRECT: begin
        ofs_o    = disp_sum;
        is_mem_o = 1'b1;
      end
      AM_REGIND: begin
        ofs_o    = base_i;
        is_mem_o = 1'b1;
      end
      AM_BASEDISP: begin
        ofs_o    = base_i + disp_sum;
        is_mem_o = 1'b1;
      end
      AM_BASEIDX: begin
        ofs_o    = base_i + scaled_idx + disp_sum;
        is_mem_o = 1'b1;
      end
      default: begin
        ofs_o    = '0;
        is_mem_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/seg_agu_segsel.sv
// Chooses the segment/offset pair for an access from its kind and any override.
module seg_agu_segsel
  import seg_agu_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int NSEG  = 4,
  localparam int SEL_W = $clog2(NSEG)
) (
  input  logic [1:0]            kind_i,
  input  logic                  ovr_en_i,
  input  logic [SEL_W-1:0]      ovr_sel_i,
  input  logic [NSEG*OFS_W-1:0] seg_regs_i,
  input  logic [OFS_W-1:0]      data_ofs_i,
  input  logic [OFS_W-1:0]      ip_i,
  input  logic [OFS_W-1:0]      sp_i,
  output logic [OFS_W-1:0]      seg_o,
  output logic [OFS_W-1:0]      ofs_o,
  output logic                  kind_ok_o
);

  logic [OFS_W-1:0] seg_arr [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_unpack
    assign seg_arr[g] = seg_regs_i[g*OFS_W +: OFS_W];
  end

  always_comb begin
    seg_o     = '0;
    ofs_o     = '0;
    kind_ok_o = 1'b1;
    case (akind_e'(kind_i))
      AK_DATA: begin
        seg_o = ovr_en_i ? seg_arr[ovr_sel_i] : seg_arr[SEL_W'(SLOT_DATA)];
        ofs_o = data_ofs_i;
      end
      AK_STACK: begin
        seg_o = seg_arr[SEL_W'(SLOT_STACK)];
        ofs_o = sp_i;
      end
      AK_FETCH: begin
        seg_o = seg_arr[SEL_W'(SLOT_CODE)];
        ofs_o = ip_i;
      end
      default: begin
        kind_ok_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/seg_agu_phys.sv
// Physical address: segment moved up by SEG_SHIFT plus zero-extended offset.
module seg_agu_phys #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic [OFS_W-1:0]  seg_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [PHYS_W-1:0] paddr_o
);

  always_comb begin
    paddr_o = {seg_i, {SEG_SHIFT{1'b0}}} + PHYS_W'(ofs_i);
  end

endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NSEG      = 4,
  parameter int SCL_W     = 2,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT,
  localparam int SEL_W    = $clog2(NSEG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [1:0]            kind_i,
  input  logic [2:0]            mode_i,
  input  logic [OFS_W-1:0]      base_i,
  input  logic [OFS_W-1:0]      index_i,
  input  logic [SCL_W-1:0]      scale_i,
  input  logic [OFS_W-1:0]      disp_lead_i,
  input  logic [OFS_W-1:0]      disp_inner_i,
  input  logic [OFS_W-1:0]      ip_i,
  input  logic [OFS_W-1:0]      sp_i,
  input  logic                  ovr_en_i,
  input  logic [SEL_W-1:0]      ovr_sel_i,
  input  logic [NSEG*OFS_W-1:0] seg_regs_i,
  output logic [PHYS_W-1:0]     paddr_o,
  output logic                  mem_valid_o,
  output logic [OFS_W-1:0]      imm_o,
  output logic                  imm_valid_o
);

  logic [OFS_W-1:0]  data_ofs;
  logic              is_mem;
  logic              is_imm;
  logic [OFS_W-1:0]  sel_seg;
  logic [OFS_W-1:0]  sel_ofs;
  logic              kind_ok;
  logic [PHYS_W-1:0] phys;

  seg_agu_offset #(.OFS_W(OFS_W), .SCL_W(SCL_W)) u_offset (
    .mode_i       (mode_i),
    .base_i       (base_i),
    .index_i      (index_i),
    .scale_i      (scale_i),
    .disp_lead_i  (disp_lead_i),
    .disp_inner_i (disp_inner_i),
    .ofs_o        (data_ofs),
    .is_mem_o     (is_mem),
    .is_imm_o     (is_imm)
  );

  seg_agu_segsel #(.OFS_W(OFS_W), .NSEG(NSEG)) u_segsel (
    .kind_i     (kind_i),
    .ovr_en_i   (ovr_en_i),
    .ovr_sel_i  (ovr_sel_i),
    .seg_regs_i (seg_regs_i),
    .data_ofs_i (data_ofs),
    .ip_i       (ip_i),
    .sp_i       (sp_i),
    .seg_o      (sel_seg),
    .ofs_o      (sel_ofs),
    .kind_ok_o  (kind_ok)
  );

  seg_agu_phys #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .seg_i   (sel_seg),
    .ofs_i   (sel_ofs),
    .paddr_o (phys)
  );

  // next state
  logic              is_data;
  logic              mem_v_d;
  logic              imm_v_d;
  logic [PHYS_W-1:0] paddr_d;
  logic [OFS_W-1:0]  imm_d;
  logic              paddr_q_en;
  logic              imm_q_en;

  always_comb begin
    is_data    = (akind_e'(kind_i) == AK_DATA);
    mem_v_d    = req_i && kind_ok && (!is_data || is_mem);
    imm_v_d    = req_i && is_data && is_imm;
    paddr_q_en = mem_v_d;
    imm_q_en   = imm_v_d;
    paddr_d    = paddr_q_en ? phys : paddr_o;
    imm_d      = imm_q_en ? disp_lead_i : imm_o;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_o     <= '0;
      imm_o       <= '0;
      mem_valid_o <= 1'b0;
      imm_valid_o <= 1'b0;
    end else begin
      paddr_o     <= paddr_d;
      imm_o       <= imm_d;
      mem_valid_o <= mem_v_d;
      imm_valid_o <= imm_v_d;
    end
  end

  // checks
  logic [OFS_W-1:0] seg_code_w;
  assign seg_code_w = seg_regs_i[SLOT_CODE*OFS_W +: OFS_W];

  AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid_o && imm_valid_o)); // R11

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o || imm_valid_o) |-> $past(req_i)); // R10

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid_o |-> $stable(paddr_o)); // R10

  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && $past(kind_i) == 2'b10) |->
      paddr_o == ({$past(seg_code_w), {SEG_SHIFT{1'b0}}} + PHYS_W'($past(ip_i)))); // R8

  AST_IMM_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    imm_valid_o |-> imm_o == $past(disp_lead_i)); // R11

endmodule

// File: tb/seg_agu_tb.sv
module seg_agu_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [1:0]  kind_i;
  logic [2:0]  mode_i;
  logic [15:0] base_i, index_i, disp_lead_i, disp_inner_i, ip_i, sp_i;
  logic [1:0]  scale_i;
  logic        ovr_en_i;
  logic [1:0]  ovr_sel_i;
  logic [63:0] seg_regs_i;
  logic [19:0] paddr_o;
  logic        mem_valid_o;
  logic [15:0] imm_o;
  logic        imm_valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  seg_agu u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i), .mode_i(mode_i),
    .base_i(base_i), .index_i(index_i), .scale_i(scale_i),
    .disp_lead_i(disp_lead_i), .disp_inner_i(disp_inner_i),
    .ip_i(ip_i), .sp_i(sp_i), .ovr_en_i(ovr_en_i), .ovr_sel_i(ovr_sel_i),
    .seg_regs_i(seg_regs_i), .paddr_o(paddr_o), .mem_valid_o(mem_valid_o),
    .imm_o(imm_o), .imm_valid_o(imm_valid_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] pa(input logic [15:0] seg, input logic [15:0] ofs);
    return ({4'h0, seg} << 4) + {4'h0, ofs};
  endfunction

  function automatic logic [15:0] slot(input int k);
    return seg_regs_i[k*16 +: 16];
  endfunction

  // one request cycle, then inputs return to idle; outputs visible at next negedge
  task automatic issue();
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic set_data(input logic [15:0] b, input logic [15:0] x,
                          input logic [15:0] dl, input logic [15:0] di);
    base_i = b; index_i = x; disp_lead_i = dl; disp_inner_i = di;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [19:0] prev_pa;
    logic [15:0] prev_imm;
    rst_n = 1'b0; req_i = 1'b0; kind_i = 2'b00; mode_i = 3'd0;
    set_data(16'h0, 16'h0, 16'h0, 16'h0);
    scale_i = 2'd0; ip_i = 16'h0; sp_i = 16'h0; ovr_en_i = 1'b0; ovr_sel_i = 2'd0;
    seg_regs_i = {16'hFFFF, 16'h2000, 16'hF000, 16'h1234};
    repeat (3) @(negedge clk);
    chk("R12 mem_valid in reset", {31'd0, mem_valid_o}, 32'd0);
    chk("R12 imm_valid in reset", {31'd0, imm_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 paddr after reset", {12'd0, paddr_o}, 32'd0);
    chk("R12 imm after reset", {16'd0, imm_o}, 32'd0);
    chk("R12 valid after reset", {30'd0, mem_valid_o, imm_valid_o}, 32'd0);

    // data sweep: modes x scales x segment choice x operand sets
    for (int v = 0; v < 3; v++) begin
      for (int m = 0; m < 8; m++) begin
        for (int s = 0; s < 4; s++) begin
          for (int o = 0; o < 5; o++) begin
            logic [15:0] ofs, seg;
            logic        exp_mem, exp_imm;
            string       tag;
            case (v)
              0: set_data(16'h0100, 16'h0003, 16'd20, 16'd40);
              1: set_data(16'hFFF0, 16'h2001, 16'h8000, 16'h9000);
              default: set_data(16'h0000, 16'hFFFF, 16'h0000, 16'h0000);
            endcase
            kind_i = 2'b00; mode_i = 3'(m); scale_i = 2'(s);
            ovr_en_i = (o != 0); ovr_sel_i = 2'((o == 0) ? 3 : o - 1);
            ip_i = 16'hAAAA; sp_i = 16'h5555;
            seg = (o == 0) ? slot(3) : slot(o - 1);
            exp_mem = (m >= 1 && m <= 4);
            exp_imm = (m == 0);
            case (m)
              1: begin ofs = disp_lead_i + disp_inner_i; tag = "R3/R9/R7 direct"; end
              2: begin ofs = base_i; tag = "R4/R9 reg indirect"; end
              3: begin ofs = base_i + disp_lead_i + disp_inner_i; tag = "R5/R9/R7 base+disp"; end
              4: begin ofs = base_i + 16'(index_i << s) + disp_lead_i + disp_inner_i;
                       tag = "R6/R9/R7 scaled index"; end
              default: begin ofs = 16'h0; tag = "R13 reserved mode"; end
            endcase
            prev_pa = paddr_o; prev_imm = imm_o;
            issue();
            chk("R10/R13 mem_valid", {31'd0, mem_valid_o}, {31'd0, exp_mem});
            chk("R11 imm_valid", {31'd0, imm_valid_o}, {31'd0, exp_imm});
            if (exp_mem) chk(tag, {12'd0, paddr_o}, {12'd0, pa(seg, ofs)});
            else chk("R11/R13 paddr holds", {12'd0, paddr_o}, {12'd0, prev_pa});
            if (exp_imm) chk("R11 operand", {16'd0, imm_o}, {16'd0, disp_lead_i});
            else chk("R13 operand holds", {16'd0, imm_o}, {16'd0, prev_imm});
          end
        end
      end
    end

    // R3 displacement sum 20 + 40 into data segment 0
    seg_regs_i[63:48] = 16'h0000;
    set_data(16'h7777, 16'h1111, 16'd20, 16'd40);
    kind_i = 2'b00; mode_i = 3'd1; ovr_en_i = 1'b0;
    issue();
    chk("R3 lead 20 inner 40", {12'd0, paddr_o}, 32'd60);

    // R2 aliasing: 0000:0040 vs 0004:0000
    set_data(16'h0, 16'h0, 16'h0040, 16'h0);
    issue();
    chk("R2 alias 0000:0040", {12'd0, paddr_o}, 32'h00040);
    seg_regs_i[63:48] = 16'h0004;
    set_data(16'h0, 16'h0, 16'h0000, 16'h0);
    issue();
    chk("R2 alias 0004:0000", {12'd0, paddr_o}, 32'h00040);
    chk("R1 alias both", {12'd0, paddr_o}, {12'd0, pa(16'h0004, 16'h0000)});

    // R8 fetch and stack: mode, displacements, override ignored
    seg_regs_i = {16'h0100, 16'hFFFE, 16'hF800, 16'h3000};
    for (int k = 0; k < 8; k++) begin
      mode_i = 3'(k); ovr_en_i = k[0]; ovr_sel_i = 2'(k);
      set_data(16'h1357, 16'h2468, 16'(k * 16'h1111), 16'hF00F);
      ip_i = 16'(16'hFFF0 + k * 3); sp_i = 16'(16'h0040 + k * 16'h2001);
      kind_i = 2'b10;
      issue();
      chk("R8 fetch valid", {31'd0, mem_valid_o}, 32'd1);
      chk("R8/R1 fetch addr", {12'd0, paddr_o}, {12'd0, pa(16'hF800, ip_i)});
      kind_i = 2'b01;
      issue();
      chk("R8 stack valid", {31'd0, mem_valid_o}, 32'd1);
      chk("R8/R1 stack addr", {12'd0, paddr_o}, {12'd0, pa(16'hFFFE, sp_i)});
      chk("R8 no operand", {31'd0, imm_valid_o}, 32'd0);
    end

    // R13 reserved kind
    prev_pa = paddr_o; prev_imm = imm_o;
    kind_i = 2'b11; mode_i = 3'd0;
    issue();
    chk("R13 reserved kind valid", {30'd0, mem_valid_o, imm_valid_o}, 32'd0);
    chk("R13 reserved kind paddr", {12'd0, paddr_o}, {12'd0, prev_pa});
    chk("R13 reserved kind operand", {16'd0, imm_o}, {16'd0, prev_imm});

    // R10 single-cycle strobe and hold while idle
    kind_i = 2'b00; mode_i = 3'd2; set_data(16'hBEEF, 16'h0, 16'h0, 16'h0);
    issue();
    prev_pa = paddr_o;
    chk("R10 strobe", {31'd0, mem_valid_o}, 32'd1);
    base_i = 16'h1234;
    @(negedge clk);
    chk("R10 strobe drops", {31'd0, mem_valid_o}, 32'd0);
    chk("R10 paddr holds", {12'd0, paddr_o}, {12'd0, prev_pa});
    @(negedge clk);
    chk("R10 still holding", {12'd0, paddr_o}, {12'd0, prev_pa});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule